// File: doc/BRIEF.md
# Low-Power Stop Handshake Controller

This block sits beside the serial engine of a serial flash interface controller and decides when that controller may lose its clocks. A global stop request is answered with an acknowledge only once the serial engine has reached a safe point. The safe point depends on the operating mode. In the SPI transfer modes it is the end of the current frame. In serial-flash command mode it is the completion of the command in progress. While the acknowledge is high the block holds off the start of any new frame or command, and it drops the clock enables of the memory-mapped and register-side logic.

Two further low-power controls are handled the same way. They are a software disable bit and a doze input, and doze can be excluded by a parameter. Each of them turns off only the register-side (non-memory-mapped) clock enable, and each waits for a safe point before doing so. The register-bus address, byte enables, read/write flag and write data are ANDed with the module-select input, so a register bus that is not addressed to the controller presents zeros to it.

Top module: `lp_stop_ctrl`

## Requirements
- R1: After reset, stop_ack and start_hold are 0, and clk_en_mem and clk_en_reg are 1.
- R2: When stop_req is high and eng_busy is low, stop_ack is 1 after the next rising clock edge.
- R3: With op_mode = 0 (SPI) and eng_busy high, stop_ack stays 0 until frame_bnd is sampled high together with stop_req. It is 1 after that edge.
- R4: With op_mode = 1 (serial-flash) and eng_busy high, frame_bnd has no effect. stop_ack stays 0 until eng_busy is sampled low together with stop_req.
- R5: Once stop_ack is 1, it stays 1 while stop_req stays high. It returns to 0 on the first edge at which stop_req is sampled low.
- R6: If stop_req is withdrawn before it is acknowledged, stop_ack, start_hold and both clock enables keep their run values.
- R7: start_hold equals stop_ack in every cycle.
- R8: clk_en_mem is 0 exactly while stop_ack is 1, so a clock enable never falls before the acknowledge.
- R9: When dis_bit is 1 (or doze_req is 1, with DOZE_GATES = 1), a register-side gate sets on the first edge at which the engine is at a safe point, using the same rule as R3/R4. clk_en_reg is 0 while this gate or stop_ack is 1. The gate clears on the first edge at which both controls are sampled low.
- R10: q_addr, q_be, q_rwb and q_wdata equal the matching bus inputs when bus_sel is 1, and they are all 0 when bus_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Global stop request |
| doze_req | input | 1 | Doze request |
| dis_bit | input | 1 | Module disable control bit |
| op_mode | input | 1 | 0 = SPI transfer mode, 1 = serial-flash command mode |
| eng_busy | input | 1 | Frame or command in progress |
| frame_bnd | input | 1 | Current SPI frame is at its boundary |
| bus_sel | input | 1 | Register bus addresses this module |
| bus_addr | input | ADDR_W | Register bus address |
| bus_be | input | DATA_W/8 | Register bus byte enables |
| bus_rwb | input | 1 | Register bus read (1) / write (0) |
| bus_wdata | input | DATA_W | Register bus write data |
| stop_ack | output | 1 | Stop acknowledge |
| start_hold | output | 1 | Blocks the start of a new frame or command |
| clk_en_mem | output | 1 | Clock enable for memory-mapped logic |
| clk_en_reg | output | 1 | Clock enable for register-side logic |
| q_addr | output | ADDR_W | Qualified address |
| q_be | output | DATA_W/8 | Qualified byte enables |
| q_rwb | output | 1 | Qualified read/write |
| q_wdata | output | DATA_W | Qualified write data |

## Verification
The assertions assume that the serial engine reports its state honestly. eng_busy low means no frame or command is running. frame_bnd is meaningful only in SPI mode. The engine does not start new work while start_hold is high. The stimulus changes inputs only between clock edges and always lets the engine go idle or reach a boundary, so every request it holds is eventually acknowledged. Mode, busy and boundary are swept over all combinations at each request. Both low-power controls are swept in all four settings.

// File: rtl/lp_stop_pkg.sv
package lp_stop_pkg;
   typedef enum logic {
      OPM_SPI   = 1'b0,
      OPM_FLASH = 1'b1
   } opmode_e;
endpackage

// File: rtl/lp_safe_point.sv
module lp_safe_point
   import lp_stop_pkg::*;
(
   input  logic op_mode,
   input  logic eng_busy,
   input  logic frame_bnd,
   output logic safe
);
   opmode_e mode;
   assign mode = opmode_e'(op_mode);

   always_comb begin
      unique case (mode)
         OPM_SPI:   safe = !eng_busy || frame_bnd;
         OPM_FLASH: safe = !eng_busy;
         default:   safe = 1'b0;
      endcase
   end
endmodule

// File: rtl/lp_hs_reg.sv
module lp_hs_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic safe,
   output logic grant
);
   logic grant_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_q <= 1'b0;
      else        grant_q <= req && (grant_q || safe);
   end

   assign grant = grant_q;

   assert_grant_needs_safe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !grant && !(req && safe) |=> !grant);

   assert_grant_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !grant);

   assert_grant_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant && req |=> grant);
endmodule

// File: rtl/lp_bus_qual.sv
module lp_bus_qual #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                  sel,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W/8-1:0]   be,
   input  logic                  rwb,
   input  logic [DATA_W-1:0]     wdata,
   output logic [ADDR_W-1:0]     q_addr,
   output logic [DATA_W/8-1:0]   q_be,
   output logic                  q_rwb,
   output logic [DATA_W-1:0]     q_wdata
);
   localparam int BE_W = DATA_W / 8;

   assign q_addr  = addr  & {ADDR_W{sel}};
   assign q_be    = be    & {BE_W{sel}};
   assign q_rwb   = rwb   & sel;
   assign q_wdata = wdata & {DATA_W{sel}};

   always_comb begin
      if (!sel) assert_unsel_zero_R10: assert ((q_addr == '0) && (q_wdata == '0) && !q_rwb);
   end
endmodule

// File: rtl/lp_stop_ctrl.sv
module lp_stop_ctrl
   import lp_stop_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter bit DOZE_GATES = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stop_req,
   input  logic                  doze_req,
   input  logic                  dis_bit,
   input  logic                  op_mode,
   input  logic                  eng_busy,
   input  logic                  frame_bnd,
   input  logic                  bus_sel,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W/8-1:0]   bus_be,
   input  logic                  bus_rwb,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic                  stop_ack,
   output logic                  start_hold,
   output logic                  clk_en_mem,
   output logic                  clk_en_reg,
   output logic [ADDR_W-1:0]     q_addr,
   output logic [DATA_W/8-1:0]   q_be,
   output logic                  q_rwb,
   output logic [DATA_W-1:0]     q_wdata
);
   initial begin
      assert_cfg_width: assert (DATA_W >= 8 && DATA_W % 8 == 0 && ADDR_W >= 1);
   end

   logic safe;
   logic gate_req;
   logic reg_gate;

   lp_safe_point u_safe (
      .op_mode   (op_mode),
      .eng_busy  (eng_busy),
      .frame_bnd (frame_bnd),
      .safe      (safe)
   );

   generate
      if (DOZE_GATES) begin : g_doze
         assign gate_req = dis_bit || doze_req;
      end else begin : g_nodoze
         assign gate_req = dis_bit;
      end
   endgenerate

   lp_hs_reg u_stop_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (stop_req),
      .safe  (safe),
      .grant (stop_ack)
   );

   lp_hs_reg u_gate_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (gate_req),
      .safe  (safe),
      .grant (reg_gate)
   );

   assign start_hold = stop_ack;
   assign clk_en_mem = !stop_ack;
   assign clk_en_reg = !(stop_ack || reg_gate);

   lp_bus_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .sel     (bus_sel),
      .addr    (bus_addr),
      .be      (bus_be),
      .rwb     (bus_rwb),
      .wdata   (bus_wdata),
      .q_addr  (q_addr),
      .q_be    (q_be),
      .q_rwb   (q_rwb),
      .q_wdata (q_wdata)
   );

   assert_spi_waits_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_ack && op_mode == 1'b0 && eng_busy && !frame_bnd |=> !stop_ack);

   assert_flash_waits_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_ack && op_mode == 1'b1 && eng_busy |=> !stop_ack);

   assert_idle_acks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req && !eng_busy |=> stop_ack);

   assert_regclk_safe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_reg && eng_busy && !(op_mode == 1'b0 && frame_bnd) |=> clk_en_reg);
endmodule

// File: tb/lp_stop_ctrl_tb.sv
module lp_stop_ctrl_tb;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;
   localparam int BE_W   = DATA_W / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req = 0, doze_req = 0, dis_bit = 0, op_mode = 0, eng_busy = 0, frame_bnd = 0;
   logic bus_sel = 0, bus_rwb = 0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [BE_W-1:0]   bus_be = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic stop_ack, start_hold, clk_en_mem, clk_en_reg, q_rwb;
   logic [ADDR_W-1:0] q_addr;
   logic [BE_W-1:0]   q_be;
   logic [DATA_W-1:0] q_wdata;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   lp_stop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DOZE_GATES(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .doze_req(doze_req),
      .dis_bit(dis_bit), .op_mode(op_mode), .eng_busy(eng_busy), .frame_bnd(frame_bnd),
      .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_be(bus_be), .bus_rwb(bus_rwb),
      .bus_wdata(bus_wdata), .stop_ack(stop_ack), .start_hold(start_hold),
      .clk_en_mem(clk_en_mem), .clk_en_reg(clk_en_reg), .q_addr(q_addr), .q_be(q_be),
      .q_rwb(q_rwb), .q_wdata(q_wdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic state_chk(input string tag, input logic ack, input logic gate);
      chk({tag, " ack"}, {31'b0, stop_ack}, {31'b0, ack});
      chk({"R7 ", tag, " hold"}, {31'b0, start_hold}, {31'b0, ack});
      chk({"R8 ", tag, " en_mem"}, {31'b0, clk_en_mem}, {31'b0, !ack});
      chk({"R9 ", tag, " en_reg"}, {31'b0, clk_en_reg}, {31'b0, !(ack || gate)});
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      state_chk("R1 reset", 1'b0, 1'b0);

      // R2 R3 R4 sweep over mode, busy, boundary
      for (int m = 0; m < 2; m++)
         for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++) begin
               logic e;
               e = (b == 0) || (m == 0 && f == 1);
               op_mode = m[0]; eng_busy = b[0]; frame_bnd = f[0]; stop_req = 1'b1;
               tick();
               state_chk(m == 0 ? "R2/R3 sweep" : "R2/R4 sweep", e, 1'b0);
               if (!e) begin
                  eng_busy = 1'b0; frame_bnd = 1'b0;
                  tick();
                  state_chk("R4 after done", 1'b1, 1'b0);
               end
               tick();
               state_chk("R5 hold while req", 1'b1, 1'b0);
               stop_req = 1'b0;
               tick();
               state_chk("R5 release", 1'b0, 1'b0);
            end

      // R3 multi-cycle wait for boundary in SPI
      op_mode = 1'b0; eng_busy = 1'b1; frame_bnd = 1'b0; stop_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick();
         state_chk("R3 wait frame", 1'b0, 1'b0);
      end
      frame_bnd = 1'b1;
      tick();
      frame_bnd = 1'b0;
      state_chk("R3 at boundary", 1'b1, 1'b0);
      stop_req = 1'b0;
      tick();
      state_chk("R5 release spi", 1'b0, 1'b0);

      // R4 boundary pulses ignored in flash mode
      op_mode = 1'b1; eng_busy = 1'b1; stop_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         frame_bnd = i[0];
         tick();
         state_chk("R4 boundary ignored", 1'b0, 1'b0);
      end
      frame_bnd = 1'b0; eng_busy = 1'b0;
      tick();
      state_chk("R4 cmd done", 1'b1, 1'b0);
      stop_req = 1'b0;
      tick();

      // R6 cancel before acknowledge
      op_mode = 1'b1; eng_busy = 1'b1; stop_req = 1'b1;
      tick(); tick();
      state_chk("R6 pending", 1'b0, 1'b0);
      stop_req = 1'b0;
      tick();
      eng_busy = 1'b0;
      tick();
      state_chk("R6 cancelled", 1'b0, 1'b0);

      // R9 disable / doze sweep
      for (int d = 0; d < 2; d++)
         for (int z = 0; z < 2; z++) begin
            logic g;
            g = (d == 1) || (z == 1);
            op_mode = 1'b0; eng_busy = 1'b1; frame_bnd = 1'b0;
            dis_bit = d[0]; doze_req = z[0];
            tick();
            state_chk("R9 busy no gate", 1'b0, 1'b0);
            eng_busy = 1'b0;
            tick();
            state_chk("R9 gate idle", 1'b0, g);
            dis_bit = 1'b0; doze_req = 1'b0;
            tick();
            state_chk("R9 gate cleared", 1'b0, 1'b0);
         end

      // R10 bus qualification
      for (int i = 0; i < 64; i++) begin
         logic s;
         s = i[0];
         bus_sel = s; bus_rwb = i[1];
         bus_addr = ADDR_W'(i * 37 + 5);
         bus_be = BE_W'(i >> 2);
         bus_wdata = DATA_W'(i * 1234 + 7);
         #1;
         chk("R10 addr", {24'b0, q_addr}, s ? {24'b0, ADDR_W'(i * 37 + 5)} : 32'h0);
         chk("R10 be", {30'b0, q_be}, s ? {30'b0, BE_W'(i >> 2)} : 32'h0);
         chk("R10 rwb", {31'b0, q_rwb}, s ? {31'b0, i[1]} : 32'h0);
         chk("R10 wdata", {16'b0, q_wdata}, s ? {16'b0, DATA_W'(i * 1234 + 7)} : 32'h0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule